// File: doc/BRIEF.md
# DMA Unit Cost Calculator

This block works out how many bus cycles one DMA unit costs, given the region byte of the current source and destination addresses and the unit width (16 or 32 bits). A small timing table holds four access times per memory region: sequential and nonsequential, each for 16-bit and 32-bit accesses. The table is loaded through a simple write port. The block combines two table entries with the region pairing and produces two registered costs. One is the steady-state cost of a unit. The other is the full cost of the first unit of a burst that starts from idle. It also outputs the signed difference between the two as a one-time adjustment.

A small channel controller tracks whether the channel is idle, running or paused. It arms the first-unit penalty only when a burst starts from idle. Resuming after a pause does not arm it. Each completed unit is charged against a signed cycle budget, which signals when it reaches zero or goes below zero. Data movement is not part of this block.

Top module: `dma_unit_cost`

## Requirements
- R1: The region of an address is its top byte (`srcRegion`/`dstRegion`). Region 0x02 is main RAM. Two addresses share a region only when all 8 region bits are equal. The timing entry is selected by the low 4 region bits. Each 16-bit entry holds the 16-bit sequential time in bits 3:0, the 16-bit nonsequential time in bits 7:4, the 32-bit sequential time in bits 11:8 and the 32-bit nonsequential time in bits 15:12. `wide`=1 selects the 32-bit fields.
- R2: When both regions are main RAM, `unitCost` and `firstCost` both equal the sum of the source and destination nonsequential times, and `burstAdj` is 0.
- R3: Otherwise, `unitCost` is the sum of the source and destination sequential times, plus 1 when both regions are equal.
- R4: For a 32-bit unit whose source is main RAM and whose destination lies in another region, `unitCost` is 1 less than in R3, but never below 0.
- R5: When the pair is not main-to-main, `firstCost` is the sum of the source and destination nonsequential times plus 2. `burstAdj` is always `firstCost - unitCost` as a signed value.
- R6: The three cost outputs reflect the inputs present at the previous rising clock edge.
- R7: `chStart` while idle makes the channel run and sets `firstPending`. `chStart` while running or paused changes nothing.
- R8: `unitDone` while running subtracts `firstCost` from `budgetLeft` if `firstPending` is set, and clears `firstPending`. Otherwise it subtracts `unitCost`. `unitDone` while idle or paused leaves the budget unchanged.
- R9: `chPause` moves a running channel to paused, and `chResume` returns it to running without arming the first-unit penalty. A pending penalty survives the pause. `chStop` returns the channel to idle and clears `firstPending`.
- R10: `budgetLoad` sets `budgetLeft` to `budgetInit` and overrides any charge in the same cycle. `budgetDone` is 1 exactly when the signed `budgetLeft` is 0 or below.
- R11: After reset the table is all zero, all costs are 0, `budgetLeft` is 0, `budgetDone` is 1 and the channel is idle. A table write is used from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblWe | input | 1 | Timing table write strobe |
| tblIdx | input | 4 | Table entry to write |
| tblData | input | 16 | Entry contents (four 4-bit times) |
| srcRegion | input | 8 | Source address bits 31:24 |
| dstRegion | input | 8 | Destination address bits 31:24 |
| wide | input | 1 | 1 = 32-bit units, 0 = 16-bit units |
| chStart | input | 1 | Start a burst from idle |
| chPause | input | 1 | Pause a running channel |
| chResume | input | 1 | Resume a paused channel |
| chStop | input | 1 | Return the channel to idle |
| unitDone | input | 1 | One unit has completed |
| budgetLoad | input | 1 | Load the cycle budget |
| budgetInit | input | 16 | Signed budget value to load |
| unitCost | output | 6 | Steady-state cycles per unit |
| firstCost | output | 6 | Cycles for the first unit of an idle-start burst |
| burstAdj | output | 7 | Signed firstCost minus unitCost |
| firstPending | output | 1 | Next charge uses firstCost |
| chActive | output | 1 | Channel is running |
| chPaused | output | 1 | Channel is paused |
| budgetLeft | output | 16 | Signed remaining budget |
| budgetDone | output | 1 | Budget is at or below zero |

## Verification
The cost outputs are driven with a random timing table and random region pairs. The pairs are weighted toward main RAM, so main-to-main, same-region, main-outbound and unrelated pairs all occur at both widths. Each pairing selects a different formula, so a swapped sequential/nonsequential field or a misplaced ±1 shows up as a wrong value. Directed pairs cover the rest: regions that alias the main-RAM table entry without being main RAM, the zero clamp on the outbound discount, and a table rewrite. Directed channel sequences then separate an idle start from a resume and from a start that is ignored, and drive the budget to exactly zero and then below zero.

// File: rtl/dma_cost_pkg.sv
package dma_cost_pkg;

  localparam int FIELD_W = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] nseq32;
    logic [FIELD_W-1:0] seq32;
    logic [FIELD_W-1:0] nseq16;
    logic [FIELD_W-1:0] seq16;
  } tmgEntry_t;

  localparam int ENTRY_W = $bits(tmgEntry_t);

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_PAUSE = 2'd2
  } chState_t;

  typedef struct packed {
    logic charge;
    logic useFirst;
    logic load;
  } costStrobe_t;

endpackage

// File: rtl/dma_cost_tbl.sv
module dma_cost_tbl
  import dma_cost_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic [IDX_W-1:0] wIdx,
  input  tmgEntry_t        wData,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  output tmgEntry_t        rdA,
  output tmgEntry_t        rdB
);

  tmgEntry_t ent [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent[i] <= '0;
      end else if (we && (wIdx == IDX_W'(i))) begin
        ent[i] <= wData;
      end
    end
  end

  assign rdA = ent[rdIdxA];
  assign rdB = ent[rdIdxB];

endmodule

// File: rtl/dma_cost_dp.sv
module dma_cost_dp
  import dma_cost_pkg::*;
#(
  parameter int REGION_W    = 8,
  parameter int IDX_W       = 4,
  parameter int COST_W      = 6,
  parameter int BUDGET_W    = 16,
  parameter int MAIN_REGION = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [REGION_W-1:0]        srcRegion,
  input  logic [REGION_W-1:0]        dstRegion,
  input  logic                       wide,
  input  tmgEntry_t                  srcEnt,
  input  tmgEntry_t                  dstEnt,
  input  costStrobe_t                strobe,
  input  logic signed [BUDGET_W-1:0] budgetInit,
  output logic [IDX_W-1:0]           srcIdx,
  output logic [IDX_W-1:0]           dstIdx,
  output logic [COST_W-1:0]          unitCost,
  output logic [COST_W-1:0]          firstCost,
  output logic signed [COST_W:0]     burstAdj,
  output logic signed [BUDGET_W-1:0] budgetLeft,
  output logic                       budgetDone
);

  localparam int SUM_W = COST_W + 1;
  localparam logic [REGION_W-1:0] MAIN = REGION_W'(MAIN_REGION);

  logic [FIELD_W-1:0] seqS, seqD, nseqS, nseqD;
  logic [SUM_W-1:0]   seqSum, nseqSum, baseSum, unitN, firstN;
  logic               srcMain, dstMain, bothMain, sameReg, outDiscount;
  logic [BUDGET_W-1:0] chargeAmt;

  assign srcIdx = srcRegion[IDX_W-1:0];
  assign dstIdx = dstRegion[IDX_W-1:0];

  assign srcMain     = (srcRegion == MAIN);
  assign dstMain     = (dstRegion == MAIN);
  assign bothMain    = srcMain && dstMain;
  assign sameReg     = (srcRegion == dstRegion);
  assign outDiscount = wide && srcMain && !sameReg;

  always_comb begin
    seqS  = wide ? srcEnt.seq32  : srcEnt.seq16;
    nseqS = wide ? srcEnt.nseq32 : srcEnt.nseq16;
    seqD  = wide ? dstEnt.seq32  : dstEnt.seq16;
    nseqD = wide ? dstEnt.nseq32 : dstEnt.nseq16;
  end

  assign seqSum  = SUM_W'(seqS) + SUM_W'(seqD);
  assign nseqSum = SUM_W'(nseqS) + SUM_W'(nseqD);
  assign baseSum = seqSum + SUM_W'(sameReg);

  always_comb begin
    if (bothMain) begin
      unitN  = nseqSum;
      firstN = nseqSum;
    end else begin
      if (outDiscount) begin
        unitN = (baseSum == '0) ? '0 : baseSum - SUM_W'(1);
      end else begin
        unitN = baseSum;
      end
      firstN = nseqSum + SUM_W'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitCost  <= '0;
      firstCost <= '0;
      burstAdj  <= '0;
    end else begin
      unitCost  <= unitN[COST_W-1:0];
      firstCost <= firstN[COST_W-1:0];
      burstAdj  <= signed'(firstN - unitN);
    end
  end

  assign chargeAmt = strobe.useFirst ? BUDGET_W'(firstCost) : BUDGET_W'(unitCost);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      budgetLeft <= '0;
    end else if (strobe.load) begin
      budgetLeft <= budgetInit;
    end else if (strobe.charge) begin
      budgetLeft <= budgetLeft - signed'(chargeAmt);
    end
  end

  assign budgetDone = (budgetLeft <= 0);

endmodule

// File: rtl/dma_cost_ctrl.sv
module dma_cost_ctrl
  import dma_cost_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chStart,
  input  logic        chPause,
  input  logic        chResume,
  input  logic        chStop,
  input  logic        unitDone,
  input  logic        budgetLoad,
  output costStrobe_t strobe,
  output logic        firstPending,
  output logic        chActive,
  output logic        chPaused
);

  chState_t state, stateNxt;
  logic     armed, armedNxt;

  always_comb begin
    stateNxt = state;
    armedNxt = armed;
    unique case (state)
      CH_IDLE: begin
        if (chStart) begin
          stateNxt = CH_RUN;
          armedNxt = 1'b1;
        end
      end
      CH_RUN: begin
        if (unitDone) armedNxt = 1'b0;
        if (chStop) begin
          stateNxt = CH_IDLE;
          armedNxt = 1'b0;
        end else if (chPause) begin
          stateNxt = CH_PAUSE;
        end
      end
      CH_PAUSE: begin
        if (chStop) begin
          stateNxt = CH_IDLE;
          armedNxt = 1'b0;
        end else if (chResume) begin
          stateNxt = CH_RUN;
        end
      end
      default: begin
        stateNxt = CH_IDLE;
        armedNxt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= CH_IDLE;
      armed <= 1'b0;
    end else begin
      state <= stateNxt;
      armed <= armedNxt;
    end
  end

  assign strobe.charge   = (state == CH_RUN) && unitDone;
  assign strobe.useFirst = armed;
  assign strobe.load     = budgetLoad;

  assign firstPending = armed;
  assign chActive     = (state == CH_RUN);
  assign chPaused     = (state == CH_PAUSE);

endmodule

// File: rtl/dma_unit_cost.sv
module dma_unit_cost
  import dma_cost_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int IDX_W    = $clog2(ENTRIES),
  parameter int REGION_W = 8,
  parameter int COST_W   = 6,
  parameter int BUDGET_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tblWe,
  input  logic [IDX_W-1:0]           tblIdx,
  input  logic [ENTRY_W-1:0]         tblData,
  input  logic [REGION_W-1:0]        srcRegion,
  input  logic [REGION_W-1:0]        dstRegion,
  input  logic                       wide,
  input  logic                       chStart,
  input  logic                       chPause,
  input  logic                       chResume,
  input  logic                       chStop,
  input  logic                       unitDone,
  input  logic                       budgetLoad,
  input  logic signed [BUDGET_W-1:0] budgetInit,
  output logic [COST_W-1:0]          unitCost,
  output logic [COST_W-1:0]          firstCost,
  output logic signed [COST_W:0]     burstAdj,
  output logic                       firstPending,
  output logic                       chActive,
  output logic                       chPaused,
  output logic signed [BUDGET_W-1:0] budgetLeft,
  output logic                       budgetDone
);

  tmgEntry_t          srcEnt, dstEnt;
  logic [IDX_W-1:0]   srcIdx, dstIdx;
  costStrobe_t        strobe;

  dma_cost_tbl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
    .clk    (clk),
    .rstN   (rstN),
    .we     (tblWe),
    .wIdx   (tblIdx),
    .wData  (tmgEntry_t'(tblData)),
    .rdIdxA (srcIdx),
    .rdIdxB (dstIdx),
    .rdA    (srcEnt),
    .rdB    (dstEnt)
  );

  dma_cost_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .chStart      (chStart),
    .chPause      (chPause),
    .chResume     (chResume),
    .chStop       (chStop),
    .unitDone     (unitDone),
    .budgetLoad   (budgetLoad),
    .strobe       (strobe),
    .firstPending (firstPending),
    .chActive     (chActive),
    .chPaused     (chPaused)
  );

  dma_cost_dp #(
    .REGION_W (REGION_W),
    .IDX_W    (IDX_W),
    .COST_W   (COST_W),
    .BUDGET_W (BUDGET_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcRegion  (srcRegion),
    .dstRegion  (dstRegion),
    .wide       (wide),
    .srcEnt     (srcEnt),
    .dstEnt     (dstEnt),
    .strobe     (strobe),
    .budgetInit (budgetInit),
    .srcIdx     (srcIdx),
    .dstIdx     (dstIdx),
    .unitCost   (unitCost),
    .firstCost  (firstCost),
    .burstAdj   (burstAdj),
    .budgetLeft (budgetLeft),
    .budgetDone (budgetDone)
  );

endmodule

// File: rtl/dma_unit_cost_chk.sv
module dma_unit_cost_chk #(
  parameter int REGION_W = 8,
  parameter int COST_W   = 6,
  parameter int BUDGET_W = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [REGION_W-1:0]        srcRegion,
  input logic [REGION_W-1:0]        dstRegion,
  input logic                       chStart,
  input logic                       chResume,
  input logic                       unitDone,
  input logic                       budgetLoad,
  input logic signed [BUDGET_W-1:0] budgetInit,
  input logic signed [COST_W:0]     burstAdj,
  input logic                       firstPending,
  input logic                       chActive,
  input logic                       chPaused,
  input logic signed [BUDGET_W-1:0] budgetLeft,
  input logic                       budgetDone
);

  // R2: a main-to-main pair carries no first-unit adjustment
  p_mainmain_noadj_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcRegion == REGION_W'(2) && dstRegion == REGION_W'(2)) |=> (burstAdj == 0));

  // R7: a start from idle runs the channel with the penalty armed
  p_idle_start_arms_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!chActive && !chPaused && chStart) |=> (chActive && firstPending));

  // R8: a charged unit clears the pending penalty
  p_first_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chActive && unitDone && firstPending) |=> !firstPending);

  // R8: the budget moves only on a load or a charge while running
  p_budget_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!budgetLoad && !(unitDone && chActive)) |=> $stable(budgetLeft));

  // R9: a resume does not arm the penalty
  p_resume_noarm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chPaused && chResume && !firstPending) |=> (chActive && !firstPending));

  // R10: loading a positive budget clears the done flag
  p_load_pos_r10: assert property (@(posedge clk) disable iff (!rstN)
    (budgetLoad && budgetInit > 0) |=> !budgetDone);

  // R9: the channel is never running and paused at once
  p_state_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(chActive && chPaused));

endmodule

bind dma_unit_cost dma_unit_cost_chk #(
  .REGION_W (REGION_W),
  .COST_W   (COST_W),
  .BUDGET_W (BUDGET_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .srcRegion    (srcRegion),
  .dstRegion    (dstRegion),
  .chStart      (chStart),
  .chResume     (chResume),
  .unitDone     (unitDone),
  .budgetLoad   (budgetLoad),
  .budgetInit   (budgetInit),
  .burstAdj     (burstAdj),
  .firstPending (firstPending),
  .chActive     (chActive),
  .chPaused     (chPaused),
  .budgetLeft   (budgetLeft),
  .budgetDone   (budgetDone)
);

// File: tb/dma_unit_cost_tb.sv
module dma_unit_cost_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tblWe;
  logic [3:0]  tblIdx;
  logic [15:0] tblData;
  logic [7:0]  srcRegion, dstRegion;
  logic        wide;
  logic        chStart, chPause, chResume, chStop, unitDone, budgetLoad;
  logic signed [15:0] budgetInit;
  logic [5:0]  unitCost, firstCost;
  logic signed [6:0] burstAdj;
  logic        firstPending, chActive, chPaused;
  logic signed [15:0] budgetLeft;
  logic        budgetDone;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] mt [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_unit_cost u_dut (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblIdx(tblIdx), .tblData(tblData),
    .srcRegion(srcRegion), .dstRegion(dstRegion), .wide(wide),
    .chStart(chStart), .chPause(chPause), .chResume(chResume), .chStop(chStop),
    .unitDone(unitDone), .budgetLoad(budgetLoad), .budgetInit(budgetInit),
    .unitCost(unitCost), .firstCost(firstCost), .burstAdj(burstAdj),
    .firstPending(firstPending), .chActive(chActive), .chPaused(chPaused),
    .budgetLeft(budgetLeft), .budgetDone(budgetDone)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] s, input logic [7:0] d, input logic w,
                                output int u, output int f);
    logic [15:0] es, ed;
    int ss, ns, sd, nd;
    es = mt[s[3:0]];
    ed = mt[d[3:0]];
    ss = w ? int'(es[11:8])  : int'(es[3:0]);
    ns = w ? int'(es[15:12]) : int'(es[7:4]);
    sd = w ? int'(ed[11:8])  : int'(ed[3:0]);
    nd = w ? int'(ed[15:12]) : int'(ed[7:4]);
    if (s == 8'h02 && d == 8'h02) begin
      u = ns + nd;
      f = u;
    end else begin
      u = ss + sd + ((s == d) ? 1 : 0);
      if (w && s == 8'h02 && d != s) u = (u > 0) ? u - 1 : 0;
      f = ns + nd + 2;
    end
  endfunction

  task automatic idle_inputs();
    tblWe = 0; chStart = 0; chPause = 0; chResume = 0; chStop = 0;
    unitDone = 0; budgetLoad = 0;
  endtask

  task automatic wr_tbl(input int idx, input logic [15:0] val);
    @(negedge clk);
    tblWe = 1; tblIdx = 4'(idx); tblData = val;
    mt[idx] = val;
    @(negedge clk);
    tblWe = 0;
  endtask

  task automatic cost_case(input logic [7:0] s, input logic [7:0] d, input logic w, input string tag);
    int u, f;
    @(negedge clk);
    srcRegion = s; dstRegion = d; wide = w;
    @(negedge clk);
    model(s, d, w, u, f);
    chk(tag, "unitCost", int'(unitCost), u);
    chk("R5", "firstCost", int'(firstCost), f);
    chk("R5", "burstAdj", int'(burstAdj), f - u);
  endtask

  // one cycle of control stimulus, then sample after the edge
  task automatic pulse(input logic st, input logic pa, input logic re, input logic sp, input logic ud);
    @(negedge clk);
    chStart = st; chPause = pa; chResume = re; chStop = sp; unitDone = ud;
    @(negedge clk);
    chStart = 0; chPause = 0; chResume = 0; chStop = 0; unitDone = 0;
  endtask

  task automatic load_budget(input int v);
    @(negedge clk);
    budgetLoad = 1; budgetInit = 16'(v);
    @(negedge clk);
    budgetLoad = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    int u, f, b;
    logic [7:0] s, d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) mt[i] = '0;
    rstN = 0; idle_inputs();
    tblIdx = 0; tblData = 0; srcRegion = 0; dstRegion = 0; wide = 0; budgetInit = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "unitCost@reset", int'(unitCost), 0);
    chk("R11", "budgetLeft@reset", int'(budgetLeft), 0);
    chk("R11", "budgetDone@reset", int'(budgetDone), 1);
    chk("R11", "chActive@reset", int'(chActive), 0);
    chk("R11", "firstPending@reset", int'(firstPending), 0);
    rstN = 1;

    for (int i = 0; i < 16; i++) wr_tbl(i, 16'($urandom));

    // random region pairs, weighted toward main RAM
    for (int n = 0; n < 400; n++) begin
      int pick;
      pick = int'($urandom % 4);
      s = (pick < 2) ? 8'h02 : ((pick == 2) ? 8'($urandom % 16) : 8'($urandom));
      pick = int'($urandom % 4);
      d = (pick < 2) ? 8'h02 : ((pick == 2) ? 8'($urandom % 16) : 8'($urandom));
      if ($urandom % 8 == 0) d = s;
      if (s == 8'h02 && d == 8'h02) cost_case(s, d, 1'($urandom), "R2");
      else if (s == 8'h02 && d != s) cost_case(s, d, 1'($urandom), "R4");
      else cost_case(s, d, 1'($urandom), "R3");
    end

    // R1: region 0x12 shares entry 2 but is not main RAM
    wr_tbl(2, 16'h9753);
    cost_case(8'h12, 8'h02, 1'b0, "R1");
    cost_case(8'h02, 8'h12, 1'b1, "R1");
    cost_case(8'h02, 8'h02, 1'b1, "R2");
    // R4: outbound discount clamps at zero
    wr_tbl(2, 16'hF0F0);
    wr_tbl(3, 16'hF0F0);
    cost_case(8'h02, 8'h03, 1'b1, "R4");
    chk("R4", "clamped unitCost", int'(unitCost), 0);
    // R11: rewrite entry and see it used
    wr_tbl(3, 16'h0302);
    cost_case(8'h03, 8'h03, 1'b0, "R11");
    chk("R11", "rewritten same-region", int'(unitCost), 5);
    // R6: outputs lag input by one edge
    @(negedge clk);
    srcRegion = 8'h03; dstRegion = 8'h02; wide = 1'b0;
    #1;
    chk("R6", "unitCost before edge", int'(unitCost), 5);

    // channel and budget, fixed pair 0x06 -> 0x07, 16-bit
    wr_tbl(6, 16'h0052);
    wr_tbl(7, 16'h0063);
    @(negedge clk);
    srcRegion = 8'h06; dstRegion = 8'h07; wide = 1'b0;
    @(negedge clk);
    model(8'h06, 8'h07, 1'b0, u, f);
    chk("R3", "unitCost 6->7", int'(unitCost), 5);
    chk("R5", "firstCost 6->7", int'(firstCost), 13);

    load_budget(100);
    b = 100;
    chk("R10", "budgetLeft loaded", int'(budgetLeft), b);
    chk("R10", "budgetDone after load", int'(budgetDone), 0);
    pulse(0, 0, 0, 0, 1);
    chk("R8", "unitDone idle ignored", int'(budgetLeft), b);
    pulse(1, 0, 0, 0, 0);
    chk("R7", "chActive after start", int'(chActive), 1);
    chk("R7", "firstPending after start", int'(firstPending), 1);
    pulse(0, 0, 0, 0, 1);
    b -= f;
    chk("R8", "first unit charge", int'(budgetLeft), b);
    chk("R8", "pending cleared", int'(firstPending), 0);
    pulse(0, 0, 0, 0, 1);
    b -= u;
    chk("R8", "steady unit charge", int'(budgetLeft), b);
    pulse(1, 0, 0, 0, 0);
    chk("R7", "start while running ignored", int'(firstPending), 0);
    pulse(0, 1, 0, 0, 0);
    chk("R9", "paused", int'(chPaused), 1);
    pulse(0, 0, 0, 0, 1);
    chk("R8", "unitDone paused ignored", int'(budgetLeft), b);
    pulse(1, 0, 0, 0, 0);
    chk("R7", "start while paused ignored", int'(firstPending), 0);
    pulse(0, 0, 1, 0, 0);
    chk("R9", "resumed active", int'(chActive), 1);
    chk("R9", "resume no penalty", int'(firstPending), 0);
    pulse(0, 0, 0, 0, 1);
    b -= u;
    chk("R9", "charge after resume", int'(budgetLeft), b);
    pulse(0, 0, 0, 1, 0);
    chk("R9", "stop to idle", int'(chActive), 0);

    // penalty survives a pause taken before the first unit
    pulse(1, 0, 0, 0, 0);
    pulse(0, 1, 0, 0, 0);
    pulse(0, 0, 1, 0, 0);
    chk("R9", "pending kept over pause", int'(firstPending), 1);
    // budget reaches exactly zero, then below
    load_budget(f);
    pulse(0, 0, 0, 0, 1);
    chk("R10", "budget zero", int'(budgetLeft), 0);
    chk("R10", "done at zero", int'(budgetDone), 1);
    pulse(0, 0, 0, 0, 1);
    chk("R10", "budget negative", int'(budgetLeft), -u);
    chk("R10", "done below zero", int'(budgetDone), 1);
    // load overrides a same-cycle charge
    @(negedge clk);
    budgetLoad = 1; budgetInit = 16'sd40; unitDone = 1;
    @(negedge clk);
    budgetLoad = 0; unitDone = 0;
    chk("R10", "load beats charge", int'(budgetLeft), 40);
    pulse(0, 0, 0, 1, 0);
    chk("R9", "stop clears pending", int'(firstPending), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule